// File: doc/BRIEF.md
# Eight-Operation ALU with Carry and Zero Flags

This block is the arithmetic-logic unit of a small 8-bit datapath. It takes two operands and a 3-bit operation code, and it returns one result together with two status flags. The carry flag reports the carry out of the operation. The zero flag reports an all-zero result. The unit is purely combinational, so its outputs follow its inputs within the same clock cycle.

The eight operations are no-operation, add, subtract, AND, OR, invert, increment and shift-left. Add, subtract and increment share a single adder. The unit prepares the second adder input and the carry-in from the operation code. The surrounding datapath owns the register file, the operand selection, the output driving and all sequencing.

Top module: `flag_alu`

## Requirements
- R1: Code 0 (no-operation) gives result 0x00 and carry 0, whatever the operands are.
- R2: Code 1 (add) gives result (A+B) mod 256, and carry equals bit 8 of the 9-bit sum A+B.
- R3: Code 2 (subtract) gives result (A−B) mod 256, and carry is the carry-out of A + ~B + 1. This means carry is 1 exactly when A >= B (no borrow).
- R4: Code 3 gives A AND B and code 4 gives A OR B, both with carry 0.
- R5: Code 5 (invert) gives the bitwise NOT of A, with carry 0.
- R6: Code 6 (increment) gives (A+1) mod 256, and carry is 1 only when A = 0xFF.
- R7: Code 7 (shift-left) gives {A[6:0], 0}, and carry equals A[7].
- R8: For every code, the zero flag is 1 exactly when the 8-bit result is 0x00.
- R9: For codes 0, 5, 6 and 7, operand B has no effect on the result, the carry or the zero flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 8 | First operand |
| b_i | input | 8 | Second operand |
| op_i | input | 3 | Operation code, 0 to 7 as listed in the requirements |
| res_o | output | 8 | Operation result |
| carry_o | output | 1 | Carry flag |
| zero_o | output | 1 | Zero flag, high when res_o is 0x00 |

## Verification
No register lies between the inputs and the outputs, so the result, the carry and the zero flag are all due in the same cycle that the operands and the code are applied. The bench drives each vector on the falling clock edge and samples one nanosecond later. Every comparison therefore happens after the combinational paths have settled and well before the next rising edge. The bench checks each sample against an arithmetic model written in the bench. It covers the carry and zero corners: 0xFF+0x01, equal operands in subtract, 0xFF increment, a set top bit in shift-left, and a stepped sweep of every code.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

    // Operation codes; the numeric values are fixed by the datapath decoder.
    typedef enum logic [2:0] {
        OP_NOP = 3'd0,
        OP_ADD = 3'd1,
        OP_SUB = 3'd2,
        OP_AND = 3'd3,
        OP_OR  = 3'd4,
        OP_NOT = 3'd5,
        OP_INC = 3'd6,
        OP_SHL = 3'd7
    } alu_op_e;

    localparam int unsigned OP_W = 3;

endpackage

// File: rtl/flag_alu_adder.sv
module flag_alu_adder #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);

    localparam int unsigned SW = W + 1;

    logic [SW-1:0] total_d;

    always_comb begin
        total_d = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
    end

    assign sum_o  = total_d[W-1:0];
    assign cout_o = total_d[SW-1];

endmodule

// File: rtl/flag_alu_bitwise.sv
module flag_alu_bitwise #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [1:0]   sel_i,   // 0: and, 1: or, 2: not a, 3: zero
    output logic [W-1:0] res_o
);

    for (genvar g = 0; g < W; g++) begin : g_bit
        always_comb begin
            unique case (sel_i)
                2'd0:    res_o[g] = a_i[g] & b_i[g];
                2'd1:    res_o[g] = a_i[g] | b_i[g];
                2'd2:    res_o[g] = ~a_i[g];
                default: res_o[g] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/flag_alu_shifter.sv
module flag_alu_shifter #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a_i,
    output logic [W-1:0] res_o,
    output logic         cout_o
);

    assign res_o  = {a_i[W-2:0], 1'b0};
    assign cout_o = a_i[W-1];

endmodule

// File: rtl/flag_alu.sv
module flag_alu
    import flag_alu_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0]    a_i,
    input  logic [W-1:0]    b_i,
    input  logic [OP_W-1:0] op_i,
    output logic [W-1:0]    res_o,
    output logic            carry_o,
    output logic            zero_o
);

    typedef struct packed {
        logic [W-1:0] res;
        logic         cy;
    } alu_out_t;

    alu_op_e      op_d;
    logic [W-1:0] add_b_d;
    logic         add_cin_d;
    logic [1:0]   bw_sel_d;
    logic [W-1:0] add_sum;
    logic         add_cout;
    logic [W-1:0] bw_res;
    logic [W-1:0] shl_res;
    logic         shl_cout;
    alu_out_t     out_d;

    assign op_d = alu_op_e'(op_i);

    // Operand preparation for the shared adder.
    always_comb begin
        add_b_d   = b_i;
        add_cin_d = 1'b0;
        unique case (op_d)
            OP_SUB: begin
                add_b_d   = ~b_i;
                add_cin_d = 1'b1;
            end
            OP_INC: begin
                add_b_d   = '0;
                add_cin_d = 1'b1;
            end
            default: ;
        endcase
    end

    always_comb begin
        unique case (op_d)
            OP_AND:  bw_sel_d = 2'd0;
            OP_OR:   bw_sel_d = 2'd1;
            OP_NOT:  bw_sel_d = 2'd2;
            default: bw_sel_d = 2'd3;
        endcase
    end

    flag_alu_adder #(.W(W)) adder_i (
        .a_i    (a_i),
        .b_i    (add_b_d),
        .cin_i  (add_cin_d),
        .sum_o  (add_sum),
        .cout_o (add_cout)
    );

    flag_alu_bitwise #(.W(W)) bitwise_i (
        .a_i   (a_i),
        .b_i   (b_i),
        .sel_i (bw_sel_d),
        .res_o (bw_res)
    );

    flag_alu_shifter #(.W(W)) shifter_i (
        .a_i    (a_i),
        .res_o  (shl_res),
        .cout_o (shl_cout)
    );

    // Result selection.
    always_comb begin
        out_d = '0;
        unique case (op_d)
            OP_ADD, OP_SUB, OP_INC: begin
                out_d.res = add_sum;
                out_d.cy  = add_cout;
            end
            OP_AND, OP_OR, OP_NOT: begin
                out_d.res = bw_res;
                out_d.cy  = 1'b0;
            end
            OP_SHL: begin
                out_d.res = shl_res;
                out_d.cy  = shl_cout;
            end
            default: out_d = '0;
        endcase
    end

    assign res_o   = out_d.res;
    assign carry_o = out_d.cy;
    assign zero_o  = ~|out_d.res;

endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk #(
    parameter int unsigned W = 8
) (
    input logic [W-1:0] a_i,
    input logic [W-1:0] b_i,
    input logic [2:0]   op_i,
    input logic [W-1:0] res_o,
    input logic         carry_o,
    input logic         zero_o
);

    logic [W:0] wide_sum;
    logic [W:0] wide_inc;

    assign wide_sum = {1'b0, a_i} + {1'b0, b_i};
    assign wide_inc = {1'b0, a_i} + 1'b1;

    always_comb begin
        if (!$isunknown({a_i, b_i, op_i, res_o, carry_o, zero_o})) begin
            // R1
            nop_clear_chk: assert (op_i != 3'd0 || (res_o == '0 && !carry_o))
                else $error("nop output not cleared");
            // R2
            add_sum_chk: assert (op_i != 3'd1 || {carry_o, res_o} == wide_sum)
                else $error("add mismatch");
            // R3
            sub_borrow_chk: assert (op_i != 3'd2 || (carry_o == (a_i >= b_i) && res_o == W'(a_i - b_i)))
                else $error("sub mismatch");
            // R4
            logic_nocarry_chk: assert (!(op_i == 3'd3 || op_i == 3'd4) || !carry_o)
                else $error("logic op set carry");
            // R5
            not_inv_chk: assert (op_i != 3'd5 || ((res_o ^ a_i) == '1 && !carry_o))
                else $error("not mismatch");
            // R6
            inc_wrap_chk: assert (op_i != 3'd6 || {carry_o, res_o} == wide_inc)
                else $error("inc mismatch");
            // R7
            shl_out_chk: assert (op_i != 3'd7 || (carry_o == a_i[W-1] && res_o[0] == 1'b0
                                                  && res_o[W-1:1] == a_i[W-2:0]))
                else $error("shl mismatch");
            // R8
            zero_flag_chk: assert (zero_o == (res_o == '0))
                else $error("zero flag mismatch");
        end
    end

endmodule

bind flag_alu flag_alu_chk #(.W(W)) chk_i (
    .a_i     (a_i),
    .b_i     (b_i),
    .op_i    (op_i),
    .res_o   (res_o),
    .carry_o (carry_o),
    .zero_o  (zero_o)
);

// File: tb/flag_alu_tb.sv
module flag_alu_tb_top;

    localparam int unsigned W = 8;
    localparam int unsigned MAX_CYCLES = 200000;

    logic         clk;
    logic         rst_n;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [2:0]   op;
    logic [W-1:0] res;
    logic         carry;
    logic         zero;

    int checks;
    int errors;
    bit done;

    flag_alu #(.W(W)) dut_i (
        .a_i     (a),
        .b_i     (b),
        .op_i    (op),
        .res_o   (res),
        .carry_o (carry),
        .zero_o  (zero)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    // Independent model of the operations.
    function automatic logic [W:0] model(input logic [2:0] o, input logic [W-1:0] x, input logic [W-1:0] y);
        int s;
        case (o)
            3'd0: return '0;
            3'd1: begin s = int'(x) + int'(y); return {s > 255, W'(s)}; end
            3'd2: begin s = int'(x) - int'(y); return {int'(x) >= int'(y), W'(s)}; end
            3'd3: return {1'b0, x & y};
            3'd4: return {1'b0, x | y};
            3'd5: return {1'b0, ~x};
            3'd6: begin s = int'(x) + 1; return {s > 255, W'(s)}; end
            default: return {x[W-1], x[W-2:0], 1'b0};
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] o);
        case (o)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3, 3'd4: return "R4";
            3'd5: return "R5";
            3'd6: return "R6";
            default: return "R7";
        endcase
    endfunction

    // Drive at the falling edge, sample 1 ns later (combinational path).
    task automatic apply(input logic [2:0] o, input logic [W-1:0] x, input logic [W-1:0] y);
        logic [W:0] exp_v;
        @(negedge clk);
        op = o; a = x; b = y;
        #1;
        exp_v = model(o, x, y);
        checks++;
        if ({carry, res} !== exp_v) begin
            errors++;
            $display("FAIL %s op=%0d a=%h b=%h actual res=%h c=%b expected res=%h c=%b",
                     tag_of(o), o, x, y, res, carry, exp_v[W-1:0], exp_v[W]);
        end
        checks++;
        if (zero !== (exp_v[W-1:0] == '0)) begin
            errors++;
            $display("FAIL R8 op=%0d a=%h b=%h actual z=%b expected z=%b",
                     o, x, y, zero, exp_v[W-1:0] == '0);
        end
    endtask

    task automatic t_reset_state;
        // R1: with code 0 applied out of reset the outputs are cleared
        apply(3'd0, 8'hA5, 8'h5A);
    endtask

    task automatic t_add;
        // R2 corners: no carry, carry with zero result, max+max
        apply(3'd1, 8'h12, 8'h34);
        apply(3'd1, 8'hFF, 8'h01);
        apply(3'd1, 8'hFF, 8'hFF);
        apply(3'd1, 8'h00, 8'h00);
    endtask

    task automatic t_sub;
        // R3: equal operands (carry 1, zero), borrow, no borrow
        apply(3'd2, 8'h40, 8'h40);
        apply(3'd2, 8'h01, 8'h02);
        apply(3'd2, 8'h80, 8'h7F);
        apply(3'd2, 8'h00, 8'hFF);
    endtask

    task automatic t_logic;
        // R4
        apply(3'd3, 8'hF0, 8'h0F);
        apply(3'd3, 8'hFF, 8'hC3);
        apply(3'd4, 8'h00, 8'h00);
        apply(3'd4, 8'hA0, 8'h05);
        // R5
        apply(3'd5, 8'hFF, 8'h00);
        apply(3'd5, 8'h3C, 8'hFF);
    endtask

    task automatic t_inc;
        // R6: wrap from 0xFF sets carry and zero
        apply(3'd6, 8'hFF, 8'h00);
        apply(3'd6, 8'hFE, 8'h00);
        apply(3'd6, 8'h7F, 8'h00);
    endtask

    task automatic t_shl;
        // R7: top bit out to carry, zero result when only bit 7 set
        apply(3'd7, 8'h80, 8'h00);
        apply(3'd7, 8'h41, 8'h00);
        apply(3'd7, 8'hC3, 8'h00);
    endtask

    task automatic t_unary_ignores_b;
        // R9: for codes 0,5,6,7 outputs must not move when only B changes
        logic [W+1:0] first;
        for (int k = 0; k < 4; k++) begin
            logic [2:0] o;
            o = (k == 0) ? 3'd0 : 3'(k + 4);
            @(negedge clk);
            op = o; a = 8'h96; b = 8'h00;
            #1;
            first = {carry, zero, res};
            for (int y = 1; y < 256; y += 17) begin
                @(negedge clk);
                b = 8'(y);
                #1;
                checks++;
                if ({carry, zero, res} !== first) begin
                    errors++;
                    $display("FAIL R9 op=%0d b=%h actual=%h expected=%h", o, b, {carry, zero, res}, first);
                end
            end
        end
    endtask

    task automatic t_sweep;
        // R1-to-R8 coverage: every code over a stepped operand grid
        for (int o = 0; o < 8; o++)
            for (int x = 0; x < 256; x += 3)
                for (int y = 0; y < 256; y += 29)
                    apply(3'(o), 8'(x), 8'(y));
    endtask

    initial begin
        checks = 0;
        errors = 0;
        done   = 1'b0;
        rst_n  = 1'b0;
        op = 3'd0; a = '0; b = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_add();
        t_sub();
        t_logic();
        t_inc();
        t_shl();
        t_unary_ignores_b();
        t_sweep();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (MAX_CYCLES - 10) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule